// File: doc/BRIEF.md
# Strobed Pin Capture with Change Timestamps

This block watches a handful of asynchronous digital lines and samples them on a periodic strobe that it generates from the clock. The sample spacing is therefore set by hardware and does not depend on how quickly software runs. Each sample becomes a state byte. Captured records leave on a valid/ready stream, which is meant to feed a deep FIFO or a DMA engine.

Two capture styles are offered. In periodic mode every strobe produces a record. Time is then implied by the record's position in the stream, so the timestamp field is zero. In change mode a record appears only when the sampled state differs from the one before it, or when it is the first sample after enabling. Each change record carries the value of a free-running down-counting 32-bit timestamp. Subtracting a later tag from an earlier one gives the number of clock cycles between the two samples.

The strobe divider and the capture style are taken from the inputs only while capture is disabled. Software sets them up, then raises the enable.

Top module: `pin_change_capture`

## Requirements
- R1: After reset, `rec_valid` is 0, `ovf_flag` is 0 and `rec_data` is all zeros.
- R2: Every input line passes through two flip-flops before it is sampled. Line i appears in bit 32+i of `rec_data`. Bits 39:37 are always zero.
- R3: While `cap_en` is low, the divider value D is loaded from `div_val`; a D of 0 is treated as 1. Once enabled, the first strobe falls in the D-th enabled cycle and later strobes follow every D cycles. Changing `div_val` while enabled has no effect.
- R4: In periodic mode (`chg_mode` = 0 when last disabled), every strobe yields a record whose bits 31:0 are zero.
- R5: In change mode (`chg_mode` = 1 when last disabled), a strobe yields a record only if its state differs from the previous strobe's state. The first strobe after enabling always yields a record.
- R6: The timestamp resets to 0, decrements by one every clock cycle and wraps from 0 to 32'hFFFFFFFF. A change record carries in bits 31:0 the timestamp of the cycle in which its sample was taken.
- R7: A record that is offered stays unchanged, with `rec_valid` high, until it is accepted at a clock edge where `rec_valid` and `rec_ready` are both high. A new record may load at that same edge.
- R8: If a record is due while an unaccepted record is still pending, the new record is dropped, the pending one is kept and `ovf_flag` is set. `ovf_flag` stays set until `cap_en` is low at a clock edge, which clears the flag and discards any pending record.
- R9: In change mode, every input level that lasts at least D cycles produces its own record. An irregular toggle pattern with pulses no shorter than D therefore yields one record per transition, plus the baseline record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cap_en | input | 1 | Capture enable; while low, configuration is loaded and status is cleared |
| chg_mode | input | 1 | 1 selects change records with timestamps, 0 selects periodic records |
| div_val | input | 16 | Strobe period in clock cycles |
| pins_in | input | 5 | Asynchronous input lines |
| rec_data | output | 40 | Record: state in [39:32], timestamp in [31:0] |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Consumer accepts the offered record |
| ovf_flag | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The bench first drives static lines in periodic mode. This separates the strobe spacing and the divider latching from any data dependence, and shows that a divider change in mid-run is ignored. Next, an irregular toggle on one line in change mode, with pulses from D up to about twice D, shows whether each transition produces exactly one record, with tags that differ by whole strobe periods; running it straight after reset also exposes the timestamp wrap. A stalled consumer with the lines changing underneath it shows whether the pending record is kept rather than replaced, and how the overflow flag is set and cleared. A divider of zero shows the one-sample-per-cycle limit.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned STATE_W = 8;
  localparam int unsigned TS_W    = 32;
  localparam int unsigned REC_W   = STATE_W + TS_W;
endpackage

// File: rtl/pcc_rst_sync.sv
// Reset that asserts asynchronously and releases on the second clock edge
module pcc_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/pcc_pin_sync.sv
// Two-stage synchronizer per input line (R2)
module pcc_pin_sync #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
      end
    end
    assign sync_out[i] = sync_q;
  end
endmodule

// File: rtl/pcc_strobe_gen.sv
// Programmable sample strobe; the period is latched while disabled (R3)
module pcc_strobe_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_in,
  output logic             strobe
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (div_q == '0) ? '0 : div_q - DIV_W'(1);
    strobe   = en && (cnt_q == last_cnt);
    div_d    = en ? div_q : div_in;
    if (!en)         cnt_d = '0;
    else if (strobe) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pcc_ts_counter.sv
// Free-running down counter, wraps 0 -> all ones (R6)
module pcc_ts_counter #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  logic [TS_W-1:0] ts_q, ts_d;

  always_comb ts_d = ts_q - TS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end

  assign ts = ts_q;
endmodule

// File: rtl/pcc_record_emit.sv
// Decides when a record is due, holds the one-deep output slot, tracks overflow
module pcc_record_emit #(
  parameter int unsigned STATE_W = 8,
  parameter int unsigned TS_W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    mode_in,
  input  logic                    strobe,
  input  logic [STATE_W-1:0]      state,
  input  logic [TS_W-1:0]         ts,
  input  logic                    ready,
  output logic [STATE_W+TS_W-1:0] data,
  output logic                    valid,
  output logic                    ovf,
  output logic                    mode_lat
);
  localparam int unsigned REC_W = STATE_W + TS_W;

  logic               mode_q, mode_d;
  logic               first_q, first_d;
  logic [STATE_W-1:0] prev_q, prev_d;
  logic [REC_W-1:0]   data_q, data_d;
  logic               valid_q, valid_d;
  logic               ovf_q, ovf_d;
  logic               due, slot_free, load_rec;
  logic [TS_W-1:0]    tag;

  always_comb begin
    // R4 zero tag in periodic mode, R5 change or baseline condition
    due       = strobe && (!mode_q || first_q || (state != prev_q));
    slot_free = !valid_q || ready;
    load_rec  = en && due && slot_free;
    tag       = mode_q ? ts : '0;

    mode_d  = en ? mode_q : mode_in;
    first_d = first_q;
    prev_d  = prev_q;
    data_d  = data_q;
    valid_d = valid_q;
    ovf_d   = ovf_q;

    if (!en) begin
      first_d = 1'b1;
      valid_d = 1'b0;   // R8 discard pending record
      ovf_d   = 1'b0;   // R8 clear only here
    end else begin
      if (load_rec) begin
        data_d  = {state, tag};
        valid_d = 1'b1;
      end else if (due) begin
        ovf_d   = 1'b1; // R8 newer record dropped
      end else if (valid_q && ready) begin
        valid_d = 1'b0; // R7 accepted
      end
      if (strobe) begin
        prev_d  = state;
        first_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      first_q <= 1'b1;
      prev_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      first_q <= first_d;
      prev_q  <= prev_d;
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  // Record payload register, written only on load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (load_rec) data_q <= data_d;
  end

  assign data     = data_q;
  assign valid    = valid_q;
  assign ovf      = ovf_q;
  assign mode_lat = mode_q;
endmodule

// File: rtl/pin_change_capture.sv
module pin_change_capture
  import pcc_pkg::*;
#(
  parameter int unsigned N_CH  = 5,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             chg_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic [N_CH-1:0]  pins_in,
  output logic [REC_W-1:0] rec_data,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic             ovf_flag
);
  logic               rst_s;
  logic [N_CH-1:0]    pins_s;
  logic [STATE_W-1:0] state_b;
  logic               strobe;
  logic [TS_W-1:0]    ts_val;
  logic               mode_lat;

  pcc_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_s)
  );

  pcc_pin_sync #(.WIDTH(N_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s),
    .async_in (pins_in),
    .sync_out (pins_s)
  );

  // R2 lines in the low bits, unused bits held at zero
  always_comb begin
    state_b            = '0;
    state_b[N_CH-1:0]  = pins_s;
  end

  pcc_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_s),
    .en     (cap_en),
    .div_in (div_val),
    .strobe (strobe)
  );

  pcc_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_s),
    .ts    (ts_val)
  );

  pcc_record_emit #(.STATE_W(STATE_W), .TS_W(TS_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_s),
    .en       (cap_en),
    .mode_in  (chg_mode),
    .strobe   (strobe),
    .state    (state_b),
    .ts       (ts_val),
    .ready    (rec_ready),
    .data     (rec_data),
    .valid    (rec_valid),
    .ovf      (ovf_flag),
    .mode_lat (mode_lat)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
(
  input logic             clk,
  input logic             rst_sn,
  input logic             cap_en,
  input logic             strobe,
  input logic             mode_lat,
  input logic [TS_W-1:0]  ts_val,
  input logic [REC_W-1:0] rec_data,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic             ovf_flag
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid |-> (rec_data[REC_W-1:REC_W-3] == 3'b000)); // R2

  AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rec_valid) |-> $past(strobe)); // R3

  AST_RAW_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (rec_valid && !mode_lat) |-> (rec_data[TS_W-1:0] == '0)); // R4

  AST_TS_DOWN: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (ts_val == $past(ts_val) - TS_W'(1))); // R6

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_sn)
    (rec_valid && !rec_ready && cap_en) |=> (rec_valid && $stable(rec_data))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (ovf_flag && cap_en) |=> ovf_flag); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    !cap_en |=> (!ovf_flag && !rec_valid)); // R8
endmodule

bind pin_change_capture pcc_checker u_chk (
  .clk       (clk),
  .rst_sn    (rst_s),
  .cap_en    (cap_en),
  .strobe    (strobe),
  .mode_lat  (mode_lat),
  .ts_val    (ts_val),
  .rec_data  (rec_data),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .ovf_flag  (ovf_flag)
);

// File: tb/tb_pin_change_capture.sv
`timescale 1ns/1ps
module tb_pin_change_capture;
  logic        clk;
  logic        rst_n;
  logic        cap_en;
  logic        chg_mode;
  logic [15:0] div_val;
  logic [4:0]  pins_in;
  logic [39:0] rec_data;
  logic        rec_valid;
  logic        rec_ready;
  logic        ovf_flag;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  pin_change_capture dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .chg_mode  (chg_mode),
    .div_val   (div_val),
    .pins_in   (pins_in),
    .rec_data  (rec_data),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .ovf_flag  (ovf_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]  m_rs;
  logic [4:0]  m_s1, m_s2;
  logic [15:0] m_div, m_cnt, m_lastc;
  logic        m_mode, m_first, m_valid, m_ovf, m_stb, m_due;
  logic [7:0]  m_prev, m_smp;
  logic [39:0] m_data;
  logic [31:0] m_ts;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rs = 2'b00; m_s1 = '0; m_s2 = '0; m_div = '0; m_cnt = '0;
      m_mode = 1'b0; m_first = 1'b1; m_valid = 1'b0; m_ovf = 1'b0;
      m_prev = '0; m_data = '0; m_ts = '0;
    end else if (!m_rs[1]) begin
      m_rs = {m_rs[0], 1'b1};
    end else begin
      m_lastc = (m_div == 0) ? 16'd0 : m_div - 16'd1;
      m_stb   = cap_en && (m_cnt == m_lastc);
      m_smp   = {3'b000, m_s2};
      m_due   = m_stb && (!m_mode || m_first || (m_smp != m_prev));
      if (!cap_en) begin
        m_valid = 1'b0; m_ovf = 1'b0; m_first = 1'b1; m_cnt = '0;
        m_div = div_val; m_mode = chg_mode;
      end else begin
        if (m_due && (!m_valid || rec_ready)) begin
          m_data  = {m_smp, (m_mode ? m_ts : 32'h0)};
          m_valid = 1'b1;
        end else if (m_due) m_ovf = 1'b1;
        else if (m_valid && rec_ready) m_valid = 1'b0;
        if (m_stb) begin m_prev = m_smp; m_first = 1'b0; m_cnt = '0; end
        else m_cnt = m_cnt + 16'd1;
      end
      m_ts = m_ts - 32'd1;
      m_s2 = m_s1;
      m_s1 = pins_in;
    end
    if (!done) begin
      chk(rec_valid === m_valid, "R7 valid vs model", 64'(rec_valid), 64'(m_valid));
      chk(ovf_flag === m_ovf, "R8 overflow vs model", 64'(ovf_flag), 64'(m_ovf));
      if (m_valid) chk(rec_data === m_data, "R5 record vs model", 64'(rec_data), 64'(m_data));
    end
  end

  // ---------------- accepted record log ----------------
  int          q_cyc[$];
  logic [39:0] q_rec[$];

  always @(posedge clk) begin
    if (rst_n && rec_valid && rec_ready) begin
      q_cyc.push_back(cyc);
      q_rec.push_back(rec_data);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    q_cyc.delete();
    q_rec.delete();
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  int          widths[6];
  logic [31:0] tdiff;
  logic [39:0] held;

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; cap_en = 1'b0; chg_mode = 1'b0; div_val = '0;
    pins_in = '0; rec_ready = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk(rec_valid == 1'b0, "R1 valid after reset", 64'(rec_valid), 0);
    chk(ovf_flag == 1'b0, "R1 ovf after reset", 64'(ovf_flag), 0);
    chk(rec_data == '0, "R1 data after reset", 64'(rec_data), 0);

    // Change mode, irregular toggles on line 0 (R5, R6, R9)
    chg_mode = 1'b1; div_val = 16'd4; pins_in = '0; rec_ready = 1'b1;
    tick(1);
    clear_log();
    cap_en = 1'b1;
    widths = '{4, 7, 5, 4, 9, 6};
    foreach (widths[i]) begin
      tick(widths[i]);
      pins_in[0] = ~pins_in[0];
    end
    tick(12);
    cap_en = 1'b0;
    tick(2);
    chk(q_rec.size() == 7, "R9 one record per transition plus baseline", 64'(q_rec.size()), 7);
    if (q_rec.size() == 7) begin
      chk(q_rec[0][39:32] == 8'h00, "R5 baseline record state", 64'(q_rec[0][39:32]), 0);
      chk(q_rec[0][31:0] >= 32'hFFFF_0000, "R6 tag wrapped below zero", 64'(q_rec[0][31:0]), 64'hFFFF_0000);
      for (int k = 1; k < 7; k++) begin
        chk(q_rec[k][39:32] == 8'(k % 2), "R5 alternating change state", 64'(q_rec[k][39:32]), 64'(k % 2));
        tdiff = q_rec[k-1][31:0] - q_rec[k][31:0];
        chk((tdiff % 4 == 0) && (tdiff != 0) && (tdiff < 32'd100), "R6 tag difference in whole periods",
            64'(tdiff), 64'(widths[k-1]));
      end
    end

    // Periodic mode, static lines, divider change ignored (R2, R3, R4)
    chg_mode = 1'b0; div_val = 16'd3; pins_in = 5'b10110;
    tick(3);
    clear_log();
    cap_en = 1'b1;
    tick(20);
    div_val = 16'd7;
    tick(20);
    cap_en = 1'b0;
    tick(2);
    chk(q_rec.size() == 13, "R3 strobe count for D=3 over 40 cycles", 64'(q_rec.size()), 13);
    for (int k = 0; k < q_rec.size(); k++) begin
      chk(q_rec[k][31:0] == 32'h0, "R4 periodic tag zero", 64'(q_rec[k][31:0]), 0);
      chk(q_rec[k][39:32] == 8'h16, "R2 state byte mapping", 64'(q_rec[k][39:32]), 64'h16);
      if (k > 0)
        chk(q_cyc[k] - q_cyc[k-1] == 3, "R3 spacing unaffected by divider change", 64'(q_cyc[k] - q_cyc[k-1]), 3);
    end

    // Divider of zero behaves as one (R3)
    div_val = 16'd0; pins_in = 5'b00001;
    tick(3);
    clear_log();
    cap_en = 1'b1;
    tick(6);
    cap_en = 1'b0;
    tick(2);
    chk(q_rec.size() == 6, "R3 divider zero gives a sample every cycle", 64'(q_rec.size()), 6);

    // Stalled consumer: overflow, hold, drain, clear (R7, R8)
    div_val = 16'd2; pins_in = 5'h03; rec_ready = 1'b0;
    tick(3);
    clear_log();
    cap_en = 1'b1;
    tick(3);
    chk(rec_valid == 1'b1, "R7 record offered", 64'(rec_valid), 1);
    held = rec_data;
    pins_in = 5'h1C;
    tick(7);
    chk(ovf_flag == 1'b1, "R8 overflow set when slot full", 64'(ovf_flag), 1);
    chk(rec_data == held, "R7 record held while not ready", 64'(rec_data), 64'(held));
    chk(rec_data[39:32] == 8'h03, "R8 older record kept", 64'(rec_data[39:32]), 3);
    rec_ready = 1'b1;
    tick(1);
    rec_ready = 1'b0;
    tick(3);
    chk(q_rec.size() == 1, "R7 single accept on one ready cycle", 64'(q_rec.size()), 1);
    if (q_rec.size() == 1)
      chk(q_rec[0][39:32] == 8'h03, "R7 accepted record content", 64'(q_rec[0][39:32]), 3);
    chk(rec_data[39:32] == 8'h1C, "R8 next record after drain", 64'(rec_data[39:32]), 64'h1C);
    chk(ovf_flag == 1'b1, "R8 overflow stays set", 64'(ovf_flag), 1);
    cap_en = 1'b0;
    tick(1);
    chk(ovf_flag == 1'b0, "R8 disable clears overflow", 64'(ovf_flag), 0);
    chk(rec_valid == 1'b0, "R8 disable discards pending record", 64'(rec_valid), 0);

    tick(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule